// File: doc/BRIEF.md
# Phase-Timed Pedestrian Crossing Controller

This block drives a two-colour pedestrian crossing. There is one light for cars and one for pedestrians, and each light is a single bit. Cars have green by default. A pedestrian asks for the crossing with a button. The request is latched while pedestrians see red. It is acted on only when an external timer marks a phase point, which it does by driving the phase-tick input high for a cycle.

The car light lives in a register and the pedestrian light is its registered complement. The lights move only in the cycle after a phase point:
- Cars that are green with a request pending turn red.
- Cars that are red always turn green again.

The request flag is cleared at every phase point. A press made while pedestrians already have green is dropped. If the tick is tied high, every cycle is a phase point. The block then behaves as a plain light: a press turns the cars red one clock later, and the next clock returns them to green.

Top module: `ped_xing_ctrl`

## Requirements
- R1: Each light output uses 1 for green and 0 for red.
- R2: `ped_green` is always the complement of `car_green`; both are never equal.
- R3: While `rst` is high at a clock edge, the outputs after that edge are `car_green`=1 and `ped_green`=0, and any stored request is discarded.
- R4: With no button press, `car_green` stays 1 across any number of phase points.
- R5: The lights change only on the clock edge at which `phase_tick` is sampled high; while `phase_tick` is low they hold.
- R6: A press sampled while `car_green`=1 and `phase_tick`=0 is remembered, and at the next phase point `car_green` becomes 0.
- R7: If `car_green` is 0 at a phase point, it becomes 1 after that edge, whatever the button does.
- R8: A press sampled while `ped_green`=1 has no effect and is not remembered: once the cars are green again, a later phase point with no new press leaves them green.
- R9: A press sampled in the same cycle as a phase point, with `car_green`=1, turns `car_green` to 0 after that edge.
- R10: The stored request is cleared at each phase point, so one press produces at most one red phase for cars.
- R11: With `phase_tick` held at 1, a press while `car_green`=1 turns `car_green` to 0 exactly one clock later, and the next clock returns it to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn | input | 1 | Pedestrian request button, sampled each clock |
| phase_tick | input | 1 | High marks a phase point from the external timer |
| car_green | output | 1 | Car light, 1 green, 0 red (registered) |
| ped_green | output | 1 | Pedestrian light, 1 green, 0 red (registered) |

## Verification
The controller is driven with several input patterns, and each one separates a different class of fault:
- An idle run with periodic ticks and no presses catches a light that drifts on its own.
- Presses on every other cycle, with sparse ticks, check that requests are remembered between ticks and cleared at each tick.
- A single early press followed by tick-free cycles confirms that nothing moves before the phase point.
- Presses made while pedestrians are green show whether they leak into the stored flag.
- A press that lands on the tick itself, and a run with the tick held high, separate the same-cycle decision and the plain one-clock toggle from a design that lags by a cycle.

// File: rtl/ped_xing_pkg.sv
package ped_xing_pkg;
  typedef enum logic {
    LAMP_RED   = 1'b0,
    LAMP_GREEN = 1'b1
  } lamp_t;

  localparam lamp_t CAR_RESET_LAMP = LAMP_GREEN;
endpackage

// File: rtl/xing_req_latch.sv
module xing_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  input  logic car_is_green,
  input  logic phase,
  output logic req_now
);
  logic pending_q;

  // A press is recorded only while pedestrians are held at red.
  always_ff @(posedge clk) begin
    if (rst)
      pending_q <= 1'b0;
    else if (phase)
      pending_q <= 1'b0;
    else if (btn && car_is_green)
      pending_q <= 1'b1;
  end

  // A press in the phase cycle itself also counts.
  assign req_now = pending_q | (btn & car_is_green);
endmodule

// File: rtl/xing_lamp_reg.sv
module xing_lamp_reg
  import ped_xing_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  phase,
  input  logic  req_now,
  output lamp_t car_lamp,
  output lamp_t ped_lamp
);
  lamp_t car_next;

  always_comb begin
    car_next = car_lamp;
    if (phase) begin
      if (car_lamp == LAMP_GREEN && req_now)
        car_next = LAMP_RED;
      else
        car_next = LAMP_GREEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car_lamp <= CAR_RESET_LAMP;
      ped_lamp <= (CAR_RESET_LAMP == LAMP_GREEN) ? LAMP_RED : LAMP_GREEN;
    end else begin
      car_lamp <= car_next;
      ped_lamp <= (car_next == LAMP_GREEN) ? LAMP_RED : LAMP_GREEN;
    end
  end
endmodule

// File: rtl/ped_xing_ctrl.sv
module ped_xing_ctrl
  import ped_xing_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic btn,
  input  logic phase_tick,
  output logic car_green,
  output logic ped_green
);
  lamp_t car_lamp;
  lamp_t ped_lamp;
  logic  req_now;

  xing_req_latch u_req (
    .clk          (clk),
    .rst          (rst),
    .btn          (btn),
    .car_is_green (car_lamp == LAMP_GREEN),
    .phase        (phase_tick),
    .req_now      (req_now)
  );

  xing_lamp_reg u_lamp (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase_tick),
    .req_now  (req_now),
    .car_lamp (car_lamp),
    .ped_lamp (ped_lamp)
  );

  assign car_green = (car_lamp == LAMP_GREEN);
  assign ped_green = (ped_lamp == LAMP_GREEN);
endmodule

// File: rtl/ped_xing_chk.sv
module ped_xing_chk (
  input logic clk,
  input logic rst,
  input logic btn,
  input logic phase_tick,
  input logic car_green,
  input logic ped_green
);
  logic seen_edge;

  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R2
  lights_complement_chk: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    car_green != ped_green);

  // R3
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (car_green && !ped_green));

  // R5
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !phase_tick |=> $stable(car_green));

  // R7
  red_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_tick && !car_green) |=> car_green);

  // R9
  press_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_tick && car_green && btn) |=> !car_green);
endmodule

bind ped_xing_ctrl ped_xing_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .btn        (btn),
  .phase_tick (phase_tick),
  .car_green  (car_green),
  .ped_green  (ped_green)
);

// File: tb/ped_xing_ctrl_bench.sv
`timescale 1ns/1ps
module ped_xing_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic phase_tick = 1'b0;
  logic car_green;
  logic ped_green;

  int checks = 0;
  int errors = 0;
  logic m_car = 1'b1;
  logic m_req = 1'b0;

  always #4 clk = ~clk;

  ped_xing_ctrl u_ped_xing_ctrl (
    .clk(clk), .rst(rst), .btn(btn), .phase_tick(phase_tick),
    .car_green(car_green), .ped_green(ped_green)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // One clock: drive at negedge, update the reference at the edge, compare after it.
  task automatic step(input logic b, input logic t, input string tag);
    @(negedge clk);
    btn = b;
    phase_tick = t;
    @(posedge clk);
    if (rst) begin
      m_car = 1'b1;
      m_req = 1'b0;
    end else if (t) begin
      if (m_car == 1'b1) m_car = !(m_req || b);
      else m_car = 1'b1;
      m_req = 1'b0;
    end else if (b && m_car) begin
      m_req = 1'b1;
    end
    #1;
    check(tag, car_green, m_car);
    check("R2", ped_green, !car_green);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(0, 0, "R3");
    rst = 1'b0;
    step(1, 1, "R9");
    check("R9", car_green, 1'b0);
    rst = 1'b1;
    step(1, 1, "R3");
    check("R3", car_green, 1'b1);
    check("R1", ped_green, 1'b0);
    rst = 1'b0;
    step(0, 1, "R3");
    check("R3", car_green, 1'b1);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 21; i++) step(0, (i % 3) == 2, "R4");
    check("R4", car_green, 1'b1);
  endtask

  task automatic t_alternate;
    for (int i = 0; i < 24; i++) step((i % 2) == 0, (i % 4) == 3, "R6");
  endtask

  task automatic t_hold_between;
    step(1, 0, "R6");
    step(0, 0, "R5");
    step(0, 0, "R5");
    check("R5", car_green, 1'b1);
    step(0, 1, "R6");
    check("R6", car_green, 1'b0);
    step(0, 1, "R7");
    check("R7", car_green, 1'b1);
    step(0, 1, "R10");
    check("R10", car_green, 1'b1);
  endtask

  task automatic t_ignore;
    step(1, 1, "R9");
    check("R9", car_green, 1'b0);
    step(1, 0, "R8");
    step(1, 0, "R8");
    check("R5", car_green, 1'b0);
    step(1, 1, "R7");
    check("R7", car_green, 1'b1);
    step(0, 0, "R8");
    step(0, 1, "R8");
    check("R8", car_green, 1'b1);
  endtask

  task automatic t_tick_high;
    step(0, 1, "R11");
    check("R11", car_green, 1'b1);
    step(1, 1, "R11");
    check("R11", car_green, 1'b0);
    step(0, 1, "R11");
    check("R11", car_green, 1'b1);
    step(1, 1, "R11");
    check("R11", car_green, 1'b0);
    step(1, 1, "R11");
    check("R11", car_green, 1'b1);
    step(1, 1, "R11");
    check("R11", car_green, 1'b0);
    step(0, 1, "R11");
    check("R11", car_green, 1'b1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_alternate();
    step(0, 1, "R7");
    t_hold_between();
    t_ignore();
    t_tick_high();
    t_alternate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule